// File: doc/BRIEF.md
# Interlocked Watchdog Refresh Controller

This block is a watchdog timer that software controls through two byte-wide control registers on an 8051-style special-function-register bus. Each register holds a group of interrupt enable bits, which are passed straight to an interrupt controller, and one watchdog flag in bit 6. A write of 1 to the flag in the second register starts the watchdog when it is idle. While the watchdog runs, that write reloads the timer only if the write just before it set the flag in the first register. A single stray write therefore cannot keep a runaway program alive.

Both flags clear themselves twelve clocks after they are set, and reads show them falling back to 0. The timer is a 16-bit down-counter. It reloads on every start or accepted refresh. When it runs out it raises a one-cycle reset request and stops. Only a system reset stops it earlier.

Top module: `wdog_sfr_ctrl`

## Requirements
- R1: After reset, reads of address 0xA8 and address 0xB8 return 0x00, `wd_running` is 0 and `wd_reset_req` is 0.
- R2: At 0xA8, bit 7 is the global enable and bits 4..0 are the serial 0, timer 1, external 1, timer 0 and external 0 enables. At 0xB8, bits 5..1 are the external 6..2 enables. These bits are stored on a write and read back, and they drive `irq_all_en`, `irq_en_lo[4:0]` and `irq_en_ext[4:0]` in the same order. Bit 5 of 0xA8 and bits 7 and 0 of 0xB8 read as 0.
- R3: Writing 1 to bit 6 of 0xA8 (the arm flag) makes that bit read 1 for exactly 12 clocks, starting from the write edge. After that it reads 0.
- R4: Writing 1 to bit 6 of 0xB8 (the kick flag) makes that bit read 1 for exactly 12 clocks. After that it reads 0.
- R5: A kick-flag write while the watchdog is idle starts it. `wd_running` is 1 from the write edge onward, and the counter is loaded with `LOAD`.
- R6: While the watchdog runs, a kick-flag write that immediately follows an arm-flag write, with no other SFR write between them, reloads the counter with `LOAD`.
- R7: While the watchdog runs, a kick-flag write without a preceding arm write does not reload the counter. An arm write that no kick write follows does not reload the counter either.
- R8: Any SFR write between the arm write and the kick write cancels the pending refresh.
- R9: Let E be the edge of the last load. `wd_reset_req` is high for exactly one cycle, registered at edge E+LOAD+1. At that same edge `wd_running` falls to 0.
- R10: Writing 0 to either flag bit neither clears the flag nor stops a running watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address for a read or write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | Write strobe, one cycle per write |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| irq_all_en | output | 1 | Global interrupt enable |
| irq_en_lo | output | 5 | Serial 0, timer 1, ext 1, timer 0, ext 0 enables |
| irq_en_ext | output | 5 | External 6..2 enables |
| wd_running | output | 1 | Watchdog is counting |
| wd_reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is a refresh attempt that looks right but must be rejected. One example is a correctly ordered pair with an unrelated write between the two halves. Another is a lone kick while the timer already runs. These rejected refreshes can only be seen in when the reset request fires. The stimulus therefore lets the timer run out after each such sequence. A scoreboard queue holds the firing cycle computed from the last legitimate load, so that an unwanted reload shows up as a late pulse and a missing reload shows up as an early one.

// File: rtl/wdog_pkg.sv
// Package: shared constants for the interlocked watchdog.
// Assumes an 8-bit SFR address space; addresses and bit positions are
// software-visible and must not move.
package wdog_pkg;
    localparam logic [7:0] ADDR_ARM_REG  = 8'hA8;
    localparam logic [7:0] ADDR_KICK_REG = 8'hB8;
    localparam int         FLAG_BIT      = 6;
    localparam int         FLAG_HOLD     = 12;
    localparam int         NUM_FLAGS     = 2;
    localparam int         IDX_ARM       = 0;
    localparam int         IDX_KICK      = 1;
endpackage

// File: rtl/wdog_selfclr_flag.sv
// Module: a flag bit that a write sets and that hardware clears HOLD clocks
// after the most recent set. Writes of 0 are not seen here (ignored).
// Assumes set_i is a one-cycle strobe from the SFR decoder.
module wdog_selfclr_flag #(
    parameter int HOLD = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic flag_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

    logic [CW-1:0] left_q;

    // Set/restart the hold window, count it down, drop the flag at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            left_q <= '0;
        end else if (set_i) begin
            flag_o <= 1'b1;
            left_q <= RELOAD;
        end else if (flag_o) begin
            if (left_q == '0) flag_o <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    // Independent age counter used only to bound the flag lifetime.
    logic [CW:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      age_q <= '0;
        else if (set_i)  age_q <= '0;
        else if (flag_o) age_q <= age_q + 1'b1;
    end

    // R3 / R4: a flag never outlives its hold window.
    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> (age_q < (CW+1)'(HOLD)));
    // R3 / R4: a set is always visible on the next cycle.
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
endmodule

// File: rtl/wdog_seq_detect.sv
// Module: start/refresh interlock. It arms when an SFR write sets the arm
// flag. Any other write disarms it, and so does the arm flag timing out.
// A kick while idle starts the watchdog; a kick while running reloads it
// only when armed.
// Assumes the wr_* strobes last one cycle and are qualified by sfr_we.
module wdog_seq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any_i,
    input  logic wr_arm_i,
    input  logic wr_kick_i,
    input  logic arm_flag_i,
    input  logic running_i,
    output logic start_o,
    output logic refresh_o
);
    logic armed_q;

    // Track whether the most recent SFR write was an arm-flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (wr_any_i)    armed_q <= wr_arm_i;
        else if (!arm_flag_i) armed_q <= 1'b0;
    end

    // Decode the kick write into a start or an accepted refresh.
    always_comb begin
        start_o   = wr_kick_i && !running_i;
        refresh_o = wr_kick_i && running_i && armed_q;
    end

    // R7: a refresh is never granted while disarmed.
    assert_no_lone_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kick_i && running_i && !armed_q) |-> !refresh_o);
    // R8: a write that does not set the arm flag leaves the detector disarmed.
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any_i && !wr_arm_i) |=> !armed_q);
endmodule

// File: rtl/wdog_countdown.sv
// Module: 16-bit style down-counter. A load (re)starts it; at zero it
// pulses the reset request and stops until the next load.
// Assumes load_i is a one-cycle strobe; running can only be cleared by expiry
// or reset.
module wdog_countdown #(
    parameter int          W    = 16,
    parameter logic [W-1:0] LOAD = 16'd300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic running_o,
    output logic expire_o
);
    logic [W-1:0] cnt_q;

    // Reload, count down, and raise the one-cycle expiry at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_o <= 1'b0;
            expire_o  <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (load_i) begin
                cnt_q     <= LOAD;
                running_o <= 1'b1;
            end else if (running_o) begin
                if (cnt_q == '0) begin
                    running_o <= 1'b0;
                    expire_o  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R9: the reset request is a single-cycle pulse.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    // R9/R10: running only ever drops together with an expiry.
    assert_stop_on_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> expire_o);
    // R5: a load always leaves the counter running.
    assert_load_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> running_o);
endmodule

// File: rtl/wdog_sfr_ctrl.sv
// Module: top of the interlocked watchdog. It decodes SFR writes to the two
// control registers, stores the interrupt enables, and instantiates the two
// self-clearing flags, the sequence detector and the countdown.
// Assumes one write per sfr_we cycle. Reads are combinational on sfr_addr.
module wdog_sfr_ctrl #(
    parameter int           CNT_W = 16,
    parameter logic [CNT_W-1:0] LOAD = 16'd300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_we,
    output logic [7:0] sfr_rdata,
    output logic       irq_all_en,
    output logic [4:0] irq_en_lo,
    output logic [4:0] irq_en_ext,
    output logic       wd_running,
    output logic       wd_reset_req
);
    import wdog_pkg::*;

    logic                 hit_arm, hit_kick;
    logic [NUM_FLAGS-1:0] flag_set, flag_q;
    logic                 start_p, refresh_p;
    logic                 all_en_q;
    logic [4:0]           en_lo_q, en_ext_q;

    // Decode which control register a write targets, and the flag sets.
    always_comb begin
        hit_arm            = sfr_we && (sfr_addr == ADDR_ARM_REG);
        hit_kick           = sfr_we && (sfr_addr == ADDR_KICK_REG);
        flag_set[IDX_ARM]  = hit_arm  && sfr_wdata[FLAG_BIT];
        flag_set[IDX_KICK] = hit_kick && sfr_wdata[FLAG_BIT];
    end

    // Store the interrupt enable fields of both registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_en_q <= 1'b0;
            en_lo_q  <= '0;
            en_ext_q <= '0;
        end else begin
            if (hit_arm) begin
                all_en_q <= sfr_wdata[7];
                en_lo_q  <= sfr_wdata[4:0];
            end
            if (hit_kick) en_ext_q <= sfr_wdata[5:1];
        end
    end

    // One self-clearing flag per control register.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        wdog_selfclr_flag #(.HOLD(FLAG_HOLD)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .flag_o (flag_q[g])
        );
    end

    wdog_seq_detect u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_any_i   (sfr_we),
        .wr_arm_i   (flag_set[IDX_ARM]),
        .wr_kick_i  (flag_set[IDX_KICK]),
        .arm_flag_i (flag_q[IDX_ARM]),
        .running_i  (wd_running),
        .start_o    (start_p),
        .refresh_o  (refresh_p)
    );

    wdog_countdown #(.W(CNT_W), .LOAD(LOAD)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_p || refresh_p),
        .running_o (wd_running),
        .expire_o  (wd_reset_req)
    );

    // Drive the enable outputs and the read-data multiplexer.
    always_comb begin
        irq_all_en = all_en_q;
        irq_en_lo  = en_lo_q;
        irq_en_ext = en_ext_q;
        unique case (sfr_addr)
            ADDR_ARM_REG:  sfr_rdata = {all_en_q, flag_q[IDX_ARM], 1'b0, en_lo_q};
            ADDR_KICK_REG: sfr_rdata = {1'b0, flag_q[IDX_KICK], en_ext_q, 1'b0};
            default:       sfr_rdata = 8'h00;
        endcase
    end

    // R2: enable outputs follow a register write on the next cycle.
    assert_enable_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_kick |=> (irq_en_ext == $past(sfr_wdata[5:1])));
    // R6: an accepted refresh keeps the watchdog running on the next cycle.
    assert_refresh_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_p |=> (wd_running && !wd_reset_req));
endmodule

// File: tb/wdog_sfr_ctrl_test.sv
module wdog_sfr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOAD_T     = 40;
    localparam logic [7:0] A_ARM  = 8'hA8;
    localparam logic [7:0] A_KICK = 8'hB8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       irq_all_en, wd_running, wd_reset_req;
    logic [4:0] irq_en_lo, irq_en_ext;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int exp_q[$];
    logic prev_req = 1'b0;

    wdog_sfr_ctrl #(.CNT_W(16), .LOAD(16'(LOAD_T))) uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .irq_all_en(irq_all_en),
        .irq_en_lo(irq_en_lo), .irq_en_ext(irq_en_ext),
        .wd_running(wd_running), .wd_reset_req(wd_reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d, output int e);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
        e = cyc;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        sfr_addr = a;
        #1;
        v = sfr_rdata;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Scoreboard monitor: every reset request must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wd_reset_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected request", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R9 request cycle", cyc, e);
                end
                check(!prev_req, "R9 one-cycle pulse", int'(prev_req), 0);
            end
            prev_req <= wd_reset_req;
        end
    end

    // Watchdog on the bench itself.
    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog timeout", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int e, s, r, l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(A_ARM, v);  check(v == 8'h00, "R1 arm reg", v, 8'h00);
        peek(A_KICK, v); check(v == 8'h00, "R1 kick reg", v, 8'h00);
        check(!wd_running && !wd_reset_req, "R1 idle", {wd_running, wd_reset_req}, 0);

        // R2 enables and bit placement
        sfr_write(A_ARM, 8'h9F, e);
        peek(A_ARM, v); check(v == 8'h9F, "R2 arm enables", v, 8'h9F);
        check(irq_all_en && irq_en_lo == 5'h1F, "R2 lo outputs", {irq_all_en, irq_en_lo}, 6'h3F);
        sfr_write(A_ARM, 8'h24, e);
        peek(A_ARM, v); check(v == 8'h04, "R2 arm bit5 reads 0", v, 8'h04);
        sfr_write(A_KICK, 8'h83, e);
        peek(A_KICK, v); check(v == 8'h02, "R2 kick unused bits", v, 8'h02);
        check(irq_en_ext == 5'h01, "R2 ext outputs", irq_en_ext, 5'h01);
        sfr_write(A_KICK, 8'h3E, e);
        peek(A_KICK, v); check(v == 8'h3E, "R2 kick enables", v, 8'h3E);
        check(irq_en_ext == 5'h1F, "R2 ext outputs all", irq_en_ext, 5'h1F);
        check(!wd_running, "R5 no start without flag", wd_running, 0);

        // R3 arm flag self-clear; R7 arm alone does not start
        sfr_write(A_ARM, 8'h40, e);
        peek(A_ARM, v); check(v == 8'h40, "R3 flag set", v, 8'h40);
        wait_until(e + 11);
        peek(A_ARM, v); check(v == 8'h40, "R3 flag at 12th cycle", v, 8'h40);
        wait_until(e + 12);
        peek(A_ARM, v); check(v == 8'h00, "R3 flag cleared", v, 8'h00);
        check(!wd_running, "R7 arm alone idle", wd_running, 0);

        // R5 start, R4 kick flag self-clear
        sfr_write(A_KICK, 8'h7E, l);
        check(wd_running, "R5 started", wd_running, 1);
        peek(A_KICK, v); check(v == 8'h7E, "R4 flag set", v, 8'h7E);
        wait_until(l + 11);
        peek(A_KICK, v); check(v == 8'h7E, "R4 flag at 12th cycle", v, 8'h7E);
        wait_until(l + 12);
        peek(A_KICK, v); check(v == 8'h3E, "R4 flag cleared", v, 8'h3E);

        // R7 lone kick and lone arm while running: no reload
        sfr_write(A_KICK, 8'h7E, e);
        sfr_write(A_ARM, 8'h40, e);
        exp_q.push_back(l + LOAD_T + 1);
        wait_until(l + LOAD_T + 4);
        check(!wd_running, "R9 stopped after expiry", wd_running, 0);
        check(exp_q.size() == 0, "R7 expiry seen", exp_q.size(), 0);

        // R6 ordered pair reloads
        sfr_write(A_KICK, 8'h7E, s);
        check(wd_running, "R5 restart", wd_running, 1);
        sfr_write(A_ARM, 8'h40, e);
        sfr_write(A_KICK, 8'h7E, r);
        exp_q.push_back(r + LOAD_T + 1);
        wait_until(r + LOAD_T + 4);
        check(exp_q.size() == 0, "R6 reloaded expiry seen", exp_q.size(), 0);
        check(!wd_running, "R9 stopped", wd_running, 0);

        // R8 intervening write cancels; R10 zero writes ignored
        sfr_write(A_KICK, 8'h7E, s);
        sfr_write(A_ARM, 8'h40, e);
        sfr_write(A_ARM, 8'h00, e);
        peek(A_ARM, v); check(v == 8'h40, "R10 arm flag survives 0 write", v, 8'h40);
        sfr_write(A_KICK, 8'h7E, e);
        sfr_write(A_KICK, 8'h3E, e);
        check(wd_running, "R10 running after clearing write", wd_running, 1);
        peek(A_KICK, v); check(v == 8'h7E, "R10 kick flag survives 0 write", v, 8'h7E);
        exp_q.push_back(s + LOAD_T + 1);
        wait_until(s + LOAD_T + 4);
        check(exp_q.size() == 0, "R8 cancelled refresh expiry", exp_q.size(), 0);
        check(!wd_running, "R9 stopped again", wd_running, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule